// File: doc/BRIEF.md
# Half-Float Framebuffer Resolve Unit

This block converts a stream of high-precision pixels into a stream of 32-bit display pixels. Each input pixel holds four signed 16-bit floating-point channels: blue, green, red and alpha. Channel values may be negative or far above 1.0. Every channel is multiplied by its own scale and offset by its own bias. The result is then limited to the unit range and reduced to 8 bits. Before that reduction, a 4x4 ordered-dither threshold is added, chosen by the low bits of the pixel's screen position. The four bytes are packed into one word, and alpha is kept.

Pixels enter and leave on valid/ready streams that carry the screen x/y position. The output stage holds a single register, so there is one cycle of latency when the output is not stalled. Scale and bias values sit on inputs. They are copied into the working set only by a pixel that is flagged as the first of a frame, so a frame never mixes settings.

Top module: `hfr_resolve`

## Requirements
- R1: A channel word is read as sign bit 15, exponent field bits 14:10 and mantissa bits 9:0. Exponent field 0 means mantissa x 2^-24. Exponent field e from 1 to 30 means (1024 + mantissa) x 2^(e-25).
- R2: Each channel value is multiplied by its scale. The magnitude of the product is truncated toward zero to a multiple of 2^-24 and capped at 2^17. The bias is then added exactly.
- R3: A channel sum below 0 gives byte 0x00. A sum of 1.0 or more gives byte 0xFF.
- R4: For a sum r with 0 <= r < 1, the byte is min(255, floor((floor(r x 4096) + D) / 16)). D is a 4-bit threshold whose bits, from bit 3 down to bit 0, are x0^y0, y0, x1^y1 and y1, using screen x and y bits.
- R5: A channel word with exponent field 31 gives 0x00 if it is a NaN (mantissa not 0) or negative infinity, and 0xFF if it is positive infinity, whatever the scale and bias.
- R6: A scale or bias word with exponent field 31 is used as 65504 with that word's sign.
- R7: Scale and bias are loaded from their inputs only when a pixel is accepted with the start-of-frame flag high, and that pixel already uses the new values. After reset the working scale is 1.0 (0x3C00) and the working bias is 0 on every channel.
- R8: Lanes are 16 bits wide in `in_pix_i`, `scale_i` and `bias_i`: blue 15:0, green 31:16, red 47:32, alpha 63:48. The output bytes are blue 7:0, green 15:8, red 23:16 and alpha 31:24.
- R9: An accepted pixel appears at the output on the next cycle, with its x/y. While the output is valid and not taken, it holds its value. The input is ready whenever the output register is empty or is being taken.
- R10: During reset and right after it, the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when valid |
| in_sof_i | input | 1 | Pixel is first of a frame; loads scale and bias |
| in_x_i | input | XW | Screen x of the input pixel |
| in_y_i | input | YW | Screen y of the input pixel |
| in_pix_i | input | 4x16 | Four half-float channels |
| scale_i | input | 4x16 | Per-channel scale, half-float |
| bias_i | input | 4x16 | Per-channel bias, half-float |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream takes the output pixel |
| out_x_o | output | XW | Screen x of the output pixel |
| out_y_o | output | YW | Screen y of the output pixel |
| out_pix_o | output | 4x8 | Packed 8:8:8:8 pixel |

## Verification
Every 16-bit channel code is driven once through four lanes with different settings. Unit scale shows the decode and dither. Half scale with a quarter bias moves the values across the threshold grid. Negative scale with a unit bias checks the sign handling and the lower clamp. A scale of 256 with a negative bias pushes most codes into saturation. The screen position changes independently of the code, so the threshold pattern is separated from the value. A second sweep uses infinite, NaN and denormal settings to show that settings are forced to the largest finite value and that products are truncated to 2^-24. Two runs with changed but unflagged settings show that only a start-of-frame pixel loads new values, and that the reset defaults apply. Random backpressure checks that output is held while stalled.

// File: rtl/hfr_pkg.sv
package hfr_pkg;
  localparam int HW   = 16;
  localparam int EXPW = 5;
  localparam int MANW = 10;
  localparam int SIGW = MANW + 1;
  localparam int KW   = EXPW;
  localparam int DTHW = 4;
  localparam logic [HW-1:0] HF_ONE = 16'h3C00;

  typedef struct packed {
    logic            neg;
    logic [SIGW-1:0] sig;
    logic [KW-1:0]   k;    // value = sig * 2^(k-24)
    logic            nan;
    logic            inf;
  } hf_dec_t;

  // 4x4 ordered threshold from interleaved position bits
  function automatic logic [DTHW-1:0] dither_thr(input logic [1:0] x, input logic [1:0] y);
    return {x[0] ^ y[0], y[0], x[1] ^ y[1], y[1]};
  endfunction
endpackage

// File: rtl/hfr_fp16_decode.sv
module hfr_fp16_decode import hfr_pkg::*; #(
  parameter bit SAT_SPECIAL = 1'b0
) (
  input  logic [HW-1:0] h_i,
  output hf_dec_t       dec_o
);
  logic [EXPW-1:0] e;
  logic [MANW-1:0] m;
  assign e = h_i[HW-2 -: EXPW];
  assign m = h_i[MANW-1:0];

  always_comb begin
    dec_o     = '0;
    dec_o.neg = h_i[HW-1];
    if (e == '1) begin
      if (SAT_SPECIAL) begin
        dec_o.sig = '1;
        dec_o.k   = KW'((2**EXPW) - 3);
      end else begin
        dec_o.nan = (m != '0);
        dec_o.inf = (m == '0);
      end
    end else if (e == '0) begin
      dec_o.sig = {1'b0, m};
    end else begin
      dec_o.sig = {1'b1, m};
      dec_o.k   = e - 1'b1;
    end
  end
endmodule

// File: rtl/hfr_lane.sv
module hfr_lane import hfr_pkg::*; #(
  parameter int QW   = 8,
  parameter int FRAC = 24,
  parameter int SATB = 41
) (
  input  logic [HW-1:0]   comp_i,
  input  logic [HW-1:0]   scale_i,
  input  logic [HW-1:0]   bias_i,
  input  logic [DTHW-1:0] thr_i,
  output logic [QW-1:0]   q_o
);
  localparam int PW   = 2 * SIGW;
  localparam int WW   = 64;
  localparam int ACCW = SATB + 3;
  localparam int TW   = QW + DTHW;
  localparam logic [WW-1:0] SAT_LIM = WW'(1) << SATB;
  localparam logic signed [ACCW-1:0] ONE = ACCW'(1) << FRAC;

  hf_dec_t dc, ds, db;

  hfr_fp16_decode #(.SAT_SPECIAL(1'b0)) u_dec_c (.h_i(comp_i),  .dec_o(dc));
  hfr_fp16_decode #(.SAT_SPECIAL(1'b1)) u_dec_s (.h_i(scale_i), .dec_o(ds));
  hfr_fp16_decode #(.SAT_SPECIAL(1'b1)) u_dec_b (.h_i(bias_i),  .dec_o(db));

  logic [PW-1:0]          prod;
  logic signed [7:0]      sh;
  logic [WW-1:0]          mag_raw, mag;
  logic [ACCW-1:0]        b_mag;
  logic signed [ACCW-1:0] p_fix, b_fix, sum;
  logic [TW:0]            t;

  assign prod = PW'(dc.sig) * PW'(ds.sig);
  assign sh   = $signed({3'b000, dc.k}) + $signed({3'b000, ds.k}) - $signed(8'(FRAC));

  always_comb begin
    if (sh < 0) mag_raw = WW'(prod) >> 8'(-sh);
    else        mag_raw = WW'(prod) << unsigned'(sh);
    mag = (mag_raw > SAT_LIM) ? SAT_LIM : mag_raw;
  end

  assign p_fix = (dc.neg ^ ds.neg) ? -$signed(ACCW'(mag)) : $signed(ACCW'(mag));
  assign b_mag = ACCW'(db.sig) << db.k;
  assign b_fix = db.neg ? -$signed(b_mag) : $signed(b_mag);
  assign sum   = p_fix + b_fix;
  assign t     = {1'b0, sum[FRAC-1 -: TW]} + (TW+1)'(thr_i);

  always_comb begin
    if (dc.nan)          q_o = '0;
    else if (dc.inf)     q_o = dc.neg ? '0 : '1;
    else if (sum < 0)    q_o = '0;
    else if (sum >= ONE) q_o = '1;
    else if (t[TW])      q_o = '1;
    else                 q_o = t[TW-1:DTHW];
  end

  logic unused_bits;
  assign unused_bits = ^{ds.nan, ds.inf, db.nan, db.inf, sum[FRAC-TW-1:0]};
endmodule

// File: rtl/hfr_resolve.sv
module hfr_resolve import hfr_pkg::*; #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int CH = 4,
  parameter int QW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_sof_i,
  input  logic [XW-1:0]    in_x_i,
  input  logic [YW-1:0]    in_y_i,
  input  logic [CH*HW-1:0] in_pix_i,
  input  logic [CH*HW-1:0] scale_i,
  input  logic [CH*HW-1:0] bias_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [XW-1:0]    out_x_o,
  output logic [YW-1:0]    out_y_o,
  output logic [CH*QW-1:0] out_pix_o
);
  localparam int IW = CH * HW;
  localparam int OW = CH * QW;

  logic [IW-1:0]   scale_q, bias_q, scale_eff, bias_eff;
  logic [OW-1:0]   q_all;
  logic [DTHW-1:0] thr;
  logic            accept;

  assign accept     = in_valid_i && in_ready_o;
  assign in_ready_o = !out_valid_o || out_ready_i;
  // frame-start pixel sees the new settings in its own cycle
  assign scale_eff  = in_sof_i ? scale_i : scale_q;
  assign bias_eff   = in_sof_i ? bias_i  : bias_q;
  assign thr        = dither_thr(in_x_i[1:0], in_y_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= {CH{HF_ONE}};
      bias_q  <= '0;
    end else if (accept && in_sof_i) begin
      scale_q <= scale_i;
      bias_q  <= bias_i;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_lane
    hfr_lane #(.QW(QW)) u_lane (
      .comp_i (in_pix_i[c*HW +: HW]),
      .scale_i(scale_eff[c*HW +: HW]),
      .bias_i (bias_eff[c*HW +: HW]),
      .thr_i  (thr),
      .q_o    (q_all[c*QW +: QW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_x_o     <= '0;
      out_y_o     <= '0;
      out_pix_o   <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_x_o   <= in_x_i;
        out_y_o   <= in_y_i;
        out_pix_o <= q_all;
      end
    end
  end
endmodule

// File: rtl/hfr_resolve_chk.sv
module hfr_resolve_chk import hfr_pkg::*; #(
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int CH = 4,
  parameter int QW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [XW-1:0]    in_x_i,
  input logic [YW-1:0]    in_y_i,
  input logic [CH*HW-1:0] in_pix_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [XW-1:0]    out_x_o,
  input logic [YW-1:0]    out_y_o,
  input logic [CH*QW-1:0] out_pix_o
);
  logic acc, b_nan, b_pinf;
  assign acc    = in_valid_i && in_ready_o;
  assign b_nan  = (in_pix_i[HW-2 -: EXPW] == '1) && (in_pix_i[MANW-1:0] != '0);
  assign b_pinf = (in_pix_i[HW-1:0] == 16'h7C00);

  // R9
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);
  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_pix_o) && $stable(out_x_o) && $stable(out_y_o)));
  // R9
  xy_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (out_x_o == $past(in_x_i) && out_y_o == $past(in_y_i)));
  // R9
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);
  // R5
  nan_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && b_nan) |=> (out_pix_o[QW-1:0] == '0));
  // R5
  inf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && b_pinf) |=> (out_pix_o[QW-1:0] == '1));
  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!out_valid_o);
    end
  end
endmodule

bind hfr_resolve hfr_resolve_chk #(.XW(XW), .YW(YW), .CH(CH), .QW(QW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_x_i(in_x_i), .in_y_i(in_y_i), .in_pix_i(in_pix_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_x_o(out_x_o), .out_y_o(out_y_o), .out_pix_o(out_pix_o)
);

// File: tb/hfr_resolve_bench.sv
module hfr_resolve_bench;
  localparam int XW = 12;
  localparam int YW = 12;
  localparam int S1 = 256;
  localparam int S2 = S1 + 65536;
  localparam int S3 = S2 + 256;
  localparam int TOTAL = S3 + 8192;
  localparam int WDOG = 190000;

  localparam logic [63:0] SETA_S = {16'h5C00, 16'hBC00, 16'h3800, 16'h3C00};
  localparam logic [63:0] SETA_B = {16'hB800, 16'h3C00, 16'h3400, 16'h0000};
  localparam logic [63:0] SETC_S = {16'hFBFF, 16'h0001, 16'h7E00, 16'h7C00};
  localparam logic [63:0] SETC_B = {16'h7BFF, 16'h0000, 16'h0001, 16'hFC00};
  localparam int BAYER [16] = '{0, 8, 2, 10, 12, 4, 14, 6, 3, 11, 1, 9, 15, 7, 13, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [XW-1:0] in_x = '0, out_x;
  logic [YW-1:0] in_y = '0, out_y;
  logic [63:0]   in_pix = '0, scale = '0, bias = '0;
  logic [31:0]   out_pix;

  hfr_resolve #(.XW(XW), .YW(YW)) u_hfr_resolve (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sof_i(in_sof), .in_x_i(in_x), .in_y_i(in_y), .in_pix_i(in_pix),
    .scale_i(scale), .bias_i(bias), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_x_o(out_x), .out_y_o(out_y), .out_pix_o(out_pix)
  );

  typedef struct packed {
    logic [31:0]      pix;
    logic [XW-1:0]    x;
    logic [YW-1:0]    y;
    logic [3:0][3:0]  tag;
  } exp_t;

  exp_t        expq[$];
  int          n_chk = 0, n_bad = 0;
  logic [63:0] act_s = {4{16'h3C00}};
  logic [63:0] act_b = '0;

  function automatic string tname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1 decode; R6 exponent-31 settings read as 65504
  function automatic real hval(input logic [15:0] h);
    int  e = int'(h[14:10]);
    real m = real'(int'(h[9:0]));
    real v;
    if (e == 31)     v = 65504.0;
    else if (e == 0) v = m * (2.0 ** (-24));
    else             v = (1024.0 + m) * (2.0 ** (e - 25));
    return h[15] ? -v : v;
  endfunction

  task automatic lane_exp(input logic [15:0] h, input logic [15:0] s, input logic [15:0] b,
                          input int x, input int y, output logic [7:0] q, output int tag);
    real    p, pm;
    longint pl, bl, r;
    int     t;
    bit     sat = 0;
    if (h[14:10] == 5'h1f) begin // R5
      tag = 5;
      q = (h[9:0] == 0 && !h[15]) ? 8'hFF : 8'h00;
      return;
    end
    p  = hval(h) * hval(s);
    pm = $floor(((p < 0.0) ? -p : p) * (2.0 ** 24)); // R2 truncate toward zero
    if (pm > 2.0 ** 41) begin pm = 2.0 ** 41; sat = 1; end
    pl = longint'(pm);
    if (p < 0.0) pl = -pl;
    bl = longint'(hval(b) * (2.0 ** 24));
    r  = pl + bl;
    tag = 4;
    if (h[14:10] == 5'h00) tag = 1;
    if (sat) tag = 2;
    if (r < 0) begin q = 8'h00; tag = 3; end           // R3
    else if (r >= 64'sd16777216) begin q = 8'hFF; tag = 3; end
    else begin                                          // R4
      t = int'(r >>> 12) + BAYER[(y % 4) * 4 + (x % 4)];
      q = (t >= 4096) ? 8'hFF : 8'(t >> 4);
    end
  endtask

  task automatic drive(input int idx);
    logic [15:0] h;
    in_x = XW'(((idx >> 3) * 3) + idx);
    in_y = YW'(idx >> 5);
    in_sof = 1'b0;
    if (idx < S1) begin // R7 reset defaults, settings ignored
      h = 16'(idx * 257);
      scale = {4{16'h4A00}};
      bias  = {4{16'h3555}};
    end else if (idx < S2) begin
      h = 16'(idx - S1);
      scale = SETA_S; bias = SETA_B;
      in_sof = (idx == S1);
    end else if (idx < S3) begin // R7 changed but unflagged
      h = 16'(idx * 97);
      scale = SETC_S; bias = SETC_B;
    end else begin
      h = 16'(((idx - S3) * 8) + ((idx - S3) >> 13));
      scale = SETC_S; bias = SETC_B;
      in_sof = (idx == S3);
    end
    in_pix = {4{h}};
  endtask

  task automatic push_exp(input int idx);
    exp_t   e;
    logic [7:0] q;
    int     tg;
    if (in_sof) begin act_s = scale; act_b = bias; end
    e.x = in_x; e.y = in_y;
    for (int j = 0; j < 4; j++) begin
      lane_exp(in_pix[16*j +: 16], act_s[16*j +: 16], act_b[16*j +: 16],
               int'(in_x), int'(in_y), q, tg);
      if (tg != 5) begin
        if (idx >= S3) tg = 6;
        else if (idx < S1 || idx >= S2) tg = 7;
      end
      e.pix[8*j +: 8] = q;
      e.tag[j] = 4'(tg);
    end
    expq.push_back(e);
  endtask

  initial begin
    int          idx = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          stall_prev = 0;
    logic [31:0] hold_pix = '0;
    exp_t        e;

    repeat (3) @(negedge clk);
    #1;
    // R10 during reset
    check(out_valid == 1'b0, "R10", "valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R10", "valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R10", "ready after reset", {31'd0, in_ready}, 32'd1);

    while ((idx < TOTAL || expq.size() > 0) && cyc < WDOG) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[1:0] != 2'b00);
      if (idx < TOTAL) begin drive(idx); in_valid = 1'b1; end
      else in_valid = 1'b0;
      #1;
      if (stall_prev)   // R9 hold while stalled
        check(out_valid && out_pix == hold_pix, "R9", "stall hold", out_pix, hold_pix);
      stall_prev = out_valid && !out_ready;
      hold_pix = out_pix;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected output", out_pix, 32'd0);
        end else begin
          e = expq.pop_front();
          for (int j = 0; j < 4; j++)
            check(out_pix[8*j +: 8] == e.pix[8*j +: 8],
                  tname(int'(e.tag[j])), $sformatf("lane%0d R8 packing", j),
                  {24'd0, out_pix[8*j +: 8]}, {24'd0, e.pix[8*j +: 8]});
          check(out_x == e.x && out_y == e.y, "R9", "x/y passthrough",
                {8'd0, out_x, out_y}, {8'd0, e.x, e.y});
        end
      end
      if (in_valid && in_ready) begin
        push_exp(idx);
        idx++;
      end
    end
    if (cyc >= WDOG) check(1'b0, "R9", "watchdog expired", 32'(idx), 32'(TOTAL));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule